// File: doc/BRIEF.md
# Dual Shadow-Register Update Scheduler

This block sits between a host and a serial register writer that feeds two identical sound chips, called the left and the right chip. For each chip it holds three banks of 25 byte-wide registers. The host bank takes host writes. The working bank is a snapshot of the host bank, taken when a pass starts. The shadow bank records the value last sent to the chip. Each pass walks all 25 addresses in a fixed order. For every address whose working value differs from its shadow, it asks the writer to send that value. The writer is driven through a start/busy handshake that carries a target select, an address and a data byte.

Sending a register costs a whole serial frame. The scheduler therefore sends one write to both chips whenever the two chips agree, both in the working value and in the value last sent. Voice control registers hold the gate bit, so they are not sent with their voice. They are held back until every oscillator and envelope register of all three voices is out. A refresh command forces every register to be sent again. It also pulses the test bit of the voice control registers, which puts the oscillators back in step.

In normal use the host writes registers at any time, and the scheduler keeps running passes back to back. A hold input stops the periodic passes during bulk updates. A refresh still runs while hold is set.

Top module: `shadow_update_sched`

## Requirements
- R1: After reset all banks read zero, `wr_start` and `pass_done` are low, and a pass over the untouched banks issues no write.
- R2: For an address where the left and right working values are equal and the left and right shadow values are also equal, at most one write is issued, with `wr_sel` = 2'b11 (both). It is issued only when the working value differs from the shadow.
- R3: For any other address, the left entry is sent first with `wr_sel` = 2'b01 if it changed, and then the right entry is sent with `wr_sel` = 2'b10 if it changed.
- R4: An address whose working and shadow values agree on both chips produces no write, so a pass that directly follows a completed pass with no host writes in between issues nothing.
- R5: A pass visits addresses in this order. First come, for voices at bases 0, 7 and 14, offsets 0,1,2,3,5,6 of each voice. Next come addresses 4, 11 and 18, the voice control registers. Last come addresses 21, 22, 23 and 24.
- R6: `wr_addr` carries the register address and `wr_data` the working value of the chip being written. The shadow of each written chip takes that value when the start is issued.
- R7: `wr_start` is a single-cycle pulse. It is raised only after a cycle with `wr_busy` low, and no further start follows until `wr_busy` has been seen low again.
- R8: A refresh sets every shadow to its host value plus one (modulo 256) and sets bit 3 in the working copy of the three control registers, then runs a full pass. It then clears bit 3 in those working copies and runs a second full pass.
- R9: While `scan_hold` is high no normal pass starts, but a refresh request is still carried out.
- R10: A host write that lands after a pass has taken its snapshot is not sent in that pass. It is sent in the next pass.
- R11: `pass_done` pulses high for exactly one cycle at the end of each pass, including each of the two refresh passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_hold | input | 1 | Suppresses normal passes while high |
| refresh_req | input | 1 | One-cycle pulse requesting a forced rewrite with test-bit sequence |
| host_we | input | 1 | Host write strobe into the host bank |
| host_side | input | 1 | Host write target: 0 left chip, 1 right chip |
| host_addr | input | 5 | Host register address; values above 24 are ignored |
| host_data | input | 8 | Host write data |
| wr_busy | input | 1 | Writer is shifting out a frame |
| wr_start | output | 1 | Single-cycle request to the writer |
| wr_sel | output | 2 | Target: 01 left, 10 right, 11 both |
| wr_addr | output | 5 | Register address for the write |
| wr_data | output | 8 | Register value for the write |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The case hardest to reach from the ports is an address where both chips hold the same new working value but their shadows differ. That case must fall back to two separate writes instead of a broadcast. The bench reaches it by first splitting the chips with different values and then writing one common value to both sides. The second hard case is a host write that arrives just after the snapshot. The bench places it in the cycle after the pass starts, on the address scanned last, and checks that it appears only in the following pass. A refresh is issued with one control register already holding bit 3, so that the bit is seen set in the first refresh pass and cleared in the second.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

   // target select on the writer interface
   typedef enum logic [1:0] {
      TGT_NONE = 2'b00,
      TGT_L    = 2'b01,
      TGT_R    = 2'b10,
      TGT_BOTH = 2'b11
   } tgt_e;

   // kind of the pass in progress
   typedef enum logic [1:0] {
      PK_NORM,
      PK_REF_SET,
      PK_REF_CLR
   } pass_e;

   // true for an address that holds a voice control register
   function automatic logic is_ctrl_reg(input int a, input int nvoice,
                                        input int vregs, input int cofs);
      return (a < nvoice * vregs) && ((a % vregs) == cofs);
   endfunction

endpackage

// File: rtl/ssu_scan_map.sv
module ssu_scan_map #(
   parameter int NVOICE     = 3,
   parameter int VREGS      = 7,
   parameter int NTAIL      = 4,
   parameter int CTRL_OFS   = 4,
   parameter int DEFER_CTRL = 1,
   parameter int NREG       = NVOICE * VREGS + NTAIL,
   parameter int AW         = $clog2(NREG)
) (
   input  logic [AW-1:0] idx_i,
   output logic [AW-1:0] addr_o
);

   localparam int PERV = VREGS - 1;        // registers per voice without control
   localparam int NOSC = NVOICE * PERV;     // scan slots used by oscillator/envelope

   generate
      if (DEFER_CTRL != 0) begin : g_defer
         always_comb begin
            int i, v, o, a;
            i = int'(idx_i);
            v = 0;
            o = 0;
            a = i;
            if (i < NOSC) begin
               v = i / PERV;
               o = i % PERV;
               a = v * VREGS + ((o < CTRL_OFS) ? o : o + 1);
            end else if (i < NVOICE * VREGS) begin
               v = i - NOSC;
               a = v * VREGS + CTRL_OFS;
            end
            addr_o = AW'(a);
         end
      end else begin : g_linear
         assign addr_o = idx_i;
      end
   endgenerate

endmodule

// File: rtl/ssu_bank.sv
module ssu_bank #(
   parameter int DW       = 8,
   parameter int NVOICE   = 3,
   parameter int VREGS    = 7,
   parameter int CTRL_OFS = 4,
   parameter int TEST_BIT = 3,
   parameter int NREG     = 25,
   parameter int AW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we_i,
   input  logic [AW-1:0] host_addr_i,
   input  logic [DW-1:0] host_data_i,
   input  logic          snap_i,
   input  logic          snap_ref_i,
   input  logic          clr_test_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic          sh_we_i,
   output logic [DW-1:0] work_o,
   output logic [DW-1:0] shad_o
);

   localparam logic [DW-1:0] TMASK = DW'(1) << TEST_BIT;

   logic [DW-1:0] host_q [NREG];
   logic [DW-1:0] work_q [NREG];
   logic [DW-1:0] shad_q [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NREG; a++) begin
            host_q[a] <= '0;
            work_q[a] <= '0;
            shad_q[a] <= '0;
         end
      end else begin
         if (host_we_i && (int'(host_addr_i) < NREG))
            host_q[host_addr_i] <= host_data_i;
         for (int a = 0; a < NREG; a++) begin
            if (snap_i) begin
               if (snap_ref_i && ssu_pkg::is_ctrl_reg(a, NVOICE, VREGS, CTRL_OFS))
                  work_q[a] <= host_q[a] | TMASK;
               else
                  work_q[a] <= host_q[a];
               if (snap_ref_i)
                  shad_q[a] <= host_q[a] + DW'(1);
            end else if (clr_test_i && ssu_pkg::is_ctrl_reg(a, NVOICE, VREGS, CTRL_OFS)) begin
               work_q[a] <= work_q[a] & ~TMASK;
            end else if (sh_we_i && (rd_addr_i == AW'(a))) begin
               shad_q[a] <= work_q[a];
            end
         end
      end
   end

   assign work_o = work_q[rd_addr_i];
   assign shad_o = shad_q[rd_addr_i];

endmodule

// File: rtl/ssu_ctrl.sv
module ssu_ctrl
   import ssu_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NREG = 25,
   parameter int AW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   input  logic          refresh_i,
   input  logic          wr_busy_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] lw_i,
   input  logic [DW-1:0] ls_i,
   input  logic [DW-1:0] rw_i,
   input  logic [DW-1:0] rs_i,
   output logic [AW-1:0] idx_o,
   output logic          snap_o,
   output logic          snap_ref_o,
   output logic          clr_test_o,
   output logic          shw_l_o,
   output logic          shw_r_o,
   output logic          wr_start_o,
   output logic [1:0]    wr_sel_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          pass_done_o
);

   typedef enum logic [2:0] {S_IDLE, S_EVAL, S_GAP, S_WAIT, S_RETEST} st_e;

   st_e           st_q;
   pass_e         kind_q;
   logic [AW-1:0] idx_q;
   logic          ph_q, adv_q, ref_pend_q;
   logic          start_q, done_q;
   tgt_e          sel_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   logic          ident, chg_l, chg_r;
   logic          iss, iss_adv, skip_adv, to_ph1, step, last;
   tgt_e          iss_sel;
   logic [DW-1:0] iss_data;

   always_comb begin
      ident    = (lw_i == rw_i) && (ls_i == rs_i);
      chg_l    = (lw_i != ls_i);
      chg_r    = (rw_i != rs_i);
      iss      = 1'b0;
      iss_adv  = 1'b0;
      skip_adv = 1'b0;
      to_ph1   = 1'b0;
      iss_sel  = TGT_NONE;
      iss_data = lw_i;
      if (st_q == S_EVAL && !wr_busy_i) begin
         if (!ph_q) begin
            if (ident) begin
               if (chg_l) begin
                  iss = 1'b1; iss_adv = 1'b1; iss_sel = TGT_BOTH;
               end else begin
                  skip_adv = 1'b1;
               end
            end else if (chg_l) begin
               iss = 1'b1; iss_sel = TGT_L;
            end else begin
               to_ph1 = 1'b1;
            end
         end else if (chg_r) begin
            iss = 1'b1; iss_adv = 1'b1; iss_sel = TGT_R; iss_data = rw_i;
         end else begin
            skip_adv = 1'b1;
         end
      end
   end

   assign last       = (idx_q == AW'(NREG - 1));
   assign step       = skip_adv || (st_q == S_WAIT && !wr_busy_i && adv_q);
   assign snap_o     = (st_q == S_IDLE) && (ref_pend_q || !hold_i);
   assign snap_ref_o = ref_pend_q;
   assign clr_test_o = (st_q == S_RETEST);
   assign shw_l_o    = iss && iss_sel[0];
   assign shw_r_o    = iss && iss_sel[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         kind_q     <= PK_NORM;
         idx_q      <= '0;
         ph_q       <= 1'b0;
         adv_q      <= 1'b0;
         ref_pend_q <= 1'b0;
         start_q    <= 1'b0;
         done_q     <= 1'b0;
         sel_q      <= TGT_NONE;
         addr_q     <= '0;
         data_q     <= '0;
      end else begin
         start_q    <= 1'b0;
         done_q     <= 1'b0;
         ref_pend_q <= (ref_pend_q && !snap_o) || refresh_i;
         case (st_q)
            S_IDLE: if (snap_o) begin
               kind_q <= ref_pend_q ? PK_REF_SET : PK_NORM;
               idx_q  <= '0;
               ph_q   <= 1'b0;
               st_q   <= S_EVAL;
            end
            S_EVAL: if (iss) begin
               start_q <= 1'b1;
               sel_q   <= iss_sel;
               addr_q  <= addr_i;
               data_q  <= iss_data;
               adv_q   <= iss_adv;
               if (!iss_adv) ph_q <= 1'b1;
               st_q    <= S_GAP;
            end else if (to_ph1) begin
               ph_q <= 1'b1;
            end
            S_GAP:    st_q <= S_WAIT;
            S_WAIT:   if (!wr_busy_i && !adv_q) st_q <= S_EVAL;
            S_RETEST: st_q <= S_EVAL;
            default:  st_q <= S_IDLE;
         endcase
         if (step) begin
            ph_q <= 1'b0;
            if (last) begin
               done_q <= 1'b1;
               idx_q  <= '0;
               if (kind_q == PK_REF_SET) begin
                  kind_q <= PK_REF_CLR;
                  st_q   <= S_RETEST;
               end else begin
                  st_q <= S_IDLE;
               end
            end else begin
               idx_q <= idx_q + AW'(1);
               st_q  <= S_EVAL;
            end
         end
      end
   end

   assign idx_o       = idx_q;
   assign wr_start_o  = start_q;
   assign wr_sel_o    = sel_q;
   assign wr_addr_o   = addr_q;
   assign wr_data_o   = data_q;
   assign pass_done_o = done_q;

   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |=> !wr_start_o);
   // R7
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> !$past(wr_busy_i));
   // R3
   sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> (wr_sel_o != 2'b00));
   // R6
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> (int'(wr_addr_o) < NREG));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done_o |=> !pass_done_o);
   // R9
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && hold_i && !ref_pend_q) |=> (st_q == S_IDLE));

endmodule

// File: rtl/shadow_update_sched.sv
module shadow_update_sched #(
   parameter int DW         = 8,
   parameter int NVOICE     = 3,
   parameter int VREGS      = 7,
   parameter int NTAIL      = 4,
   parameter int CTRL_OFS   = 4,
   parameter int TEST_BIT   = 3,
   parameter int DEFER_CTRL = 1,
   parameter int NREG       = NVOICE * VREGS + NTAIL,
   parameter int AW         = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scan_hold,
   input  logic          refresh_req,
   input  logic          host_we,
   input  logic          host_side,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_data,
   input  logic          wr_busy,
   output logic          wr_start,
   output logic [1:0]    wr_sel,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          pass_done
);

   generate
      if (TEST_BIT >= DW) begin : g_bad_test_bit
         $error("TEST_BIT must lie inside the data width");
      end
      if (CTRL_OFS >= VREGS) begin : g_bad_ctrl_ofs
         $error("CTRL_OFS must lie inside a voice");
      end
      if ((1 << AW) < NREG) begin : g_bad_aw
         $error("AW too narrow for NREG");
      end
   endgenerate

   logic [AW-1:0] idx, rd_addr;
   logic          snap, snap_ref, clr_test, shw_l, shw_r;
   logic [DW-1:0] work_w [2];
   logic [DW-1:0] shad_w [2];

   ssu_scan_map #(
      .NVOICE(NVOICE), .VREGS(VREGS), .NTAIL(NTAIL), .CTRL_OFS(CTRL_OFS),
      .DEFER_CTRL(DEFER_CTRL), .NREG(NREG), .AW(AW)
   ) i_map (
      .idx_i (idx),
      .addr_o(rd_addr)
   );

   generate
      for (genvar g = 0; g < 2; g++) begin : g_side
         ssu_bank #(
            .DW(DW), .NVOICE(NVOICE), .VREGS(VREGS), .CTRL_OFS(CTRL_OFS),
            .TEST_BIT(TEST_BIT), .NREG(NREG), .AW(AW)
         ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_we_i  (host_we && (host_side == 1'(g))),
            .host_addr_i(host_addr),
            .host_data_i(host_data),
            .snap_i     (snap),
            .snap_ref_i (snap_ref),
            .clr_test_i (clr_test),
            .rd_addr_i  (rd_addr),
            .sh_we_i    ((g == 0) ? shw_l : shw_r),
            .work_o     (work_w[g]),
            .shad_o     (shad_w[g])
         );
      end
   endgenerate

   ssu_ctrl #(.DW(DW), .NREG(NREG), .AW(AW)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (scan_hold),
      .refresh_i  (refresh_req),
      .wr_busy_i  (wr_busy),
      .addr_i     (rd_addr),
      .lw_i       (work_w[0]),
      .ls_i       (shad_w[0]),
      .rw_i       (work_w[1]),
      .rs_i       (shad_w[1]),
      .idx_o      (idx),
      .snap_o     (snap),
      .snap_ref_o (snap_ref),
      .clr_test_o (clr_test),
      .shw_l_o    (shw_l),
      .shw_r_o    (shw_r),
      .wr_start_o (wr_start),
      .wr_sel_o   (wr_sel),
      .wr_addr_o  (wr_addr),
      .wr_data_o  (wr_data),
      .pass_done_o(pass_done)
   );

endmodule

// File: tb/test_shadow_update_sched.sv
module test_shadow_update_sched;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scan_hold = 1'b1;
   logic       refresh_req = 1'b0;
   logic       host_we = 1'b0;
   logic       host_side = 1'b0;
   logic [4:0] host_addr = '0;
   logic [7:0] host_data = '0;
   logic       wr_busy = 1'b0;
   logic       wr_start;
   logic [1:0] wr_sel;
   logic [4:0] wr_addr;
   logic [7:0] wr_data;
   logic       pass_done;

   always #2 clk = ~clk;

   shadow_update_sched i_shadow_update_sched (
      .clk(clk), .rst_n(rst_n), .scan_hold(scan_hold), .refresh_req(refresh_req),
      .host_we(host_we), .host_side(host_side), .host_addr(host_addr),
      .host_data(host_data), .wr_busy(wr_busy), .wr_start(wr_start),
      .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .pass_done(pass_done)
   );

   int errors = 0;
   int checks = 0;
   bit reported = 0;

   // bench copies of the banks
   logic [7:0] hL [25], hR [25], wL [25], wR [25], eL [25], eR [25];
   int ordr [25];

   // expected writes of one pass
   int ecnt;
   int esel [64], eadr [64], edat [64];

   // writer log
   int lcount = 0;
   int lsel [2048], ladr [2048], ldat [2048], lpass [2048];
   int pass_cnt = 0;
   int bcnt = 0;
   bit prev_start = 0, prev_done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_ctl(input int a);
      return (a < 21) && (a % 7 == 4);
   endfunction

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // writer model, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_start) begin
            chk(!wr_busy, "R7 start while busy", wr_busy, 0);
            chk(!prev_start, "R7 start width", prev_start, 0);
            lsel[lcount] = wr_sel; ladr[lcount] = wr_addr;
            ldat[lcount] = wr_data; lpass[lcount] = pass_cnt;
            bcnt = (wr_addr + lcount) % 4;
            wr_busy = (bcnt > 0);
            lcount++;
         end else if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) wr_busy = 1'b0;
         end
         if (pass_done) begin
            chk(!prev_done, "R11 done width", prev_done, 0);
            pass_cnt++;
         end
         prev_start = wr_start;
         prev_done = pass_done;
      end
   end

   task automatic model_scan();
      ecnt = 0;
      for (int i = 0; i < 25; i++) begin
         int a = ordr[i];
         if (wL[a] == wR[a] && eL[a] == eR[a]) begin
            if (wL[a] != eL[a]) begin
               esel[ecnt] = 3; eadr[ecnt] = a; edat[ecnt] = wL[a]; ecnt++;
               eL[a] = wL[a]; eR[a] = wR[a];
            end
         end else begin
            if (wL[a] != eL[a]) begin
               esel[ecnt] = 1; eadr[ecnt] = a; edat[ecnt] = wL[a]; ecnt++;
               eL[a] = wL[a];
            end
            if (wR[a] != eR[a]) begin
               esel[ecnt] = 2; eadr[ecnt] = a; edat[ecnt] = wR[a]; ecnt++;
               eR[a] = wR[a];
            end
         end
      end
   endtask

   task automatic check_pass(input int p, input string tag, output int got);
      int k;
      k = 0;
      for (int j = 0; j < lcount; j++) begin
         if (lpass[j] == p) begin
            if (k < ecnt) begin
               chk(lsel[j] == esel[k], {tag, " R2 R3 select"}, lsel[j], esel[k]);
               chk(ladr[j] == eadr[k], {tag, " R5 address order"}, ladr[j], eadr[k]);
               chk(ldat[j] == edat[k], {tag, " R6 data"}, ldat[j], edat[k]);
            end
            k++;
         end
      end
      chk(k == ecnt, {tag, " write count"}, k, ecnt);
      got = k;
   endtask

   task automatic set_host(input int side, input int a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_side = side[0]; host_addr = a[4:0]; host_data = d;
      @(negedge clk);
      host_we = 1'b0;
      if (side == 0) hL[a] = d; else hR[a] = d;
   endtask

   task automatic wait_passes(input int target);
      while (pass_cnt < target) @(negedge clk);
   endtask

   task automatic do_pass(input bit inject, input string tag, output int got);
      int p;
      for (int a = 0; a < 25; a++) begin wL[a] = hL[a]; wR[a] = hR[a]; end
      model_scan();
      p = pass_cnt;
      @(negedge clk);
      scan_hold = 1'b0;
      @(negedge clk);
      scan_hold = 1'b1;
      if (inject) begin
         // R10: lands one edge after the snapshot
         host_we = 1'b1; host_side = 1'b0; host_addr = 5'd24; host_data = ~hL[24];
         @(negedge clk);
         host_we = 1'b0;
         hL[24] = ~hL[24];
      end
      wait_passes(p + 1);
      check_pass(p, tag, got);
   endtask

   initial begin
      int k, got, p0, c0;
      k = 0;
      for (int v = 0; v < 3; v++)
         for (int o = 0; o < 7; o++)
            if (o != 4) begin ordr[k] = v * 7 + o; k++; end
      for (int v = 0; v < 3; v++) begin ordr[k] = v * 7 + 4; k++; end
      for (int t = 21; t < 25; t++) begin ordr[k] = t; k++; end
      for (int a = 0; a < 25; a++) begin
         hL[a] = 0; hR[a] = 0; wL[a] = 0; wR[a] = 0; eL[a] = 0; eR[a] = 0;
      end

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(wr_start == 0, "R1 start after reset", wr_start, 0);
      chk(pass_done == 0, "R1 done after reset", pass_done, 0);
      do_pass(0, "R1", got);

      // R2 broadcast of identical values, full sweep of addresses
      for (int a = 0; a < 25; a++) begin
         set_host(0, a, 8'(a * 9 + 5));
         set_host(1, a, 8'(a * 9 + 5));
      end
      do_pass(0, "R2", got);
      chk(got == 25, "R2 broadcast count", got, 25);

      // R4 nothing changed
      do_pass(0, "R4", got);
      chk(got == 0, "R4 idle pass", got, 0);

      // R3 split pattern
      for (int a = 0; a < 25; a++) begin
         if (a % 3 == 0) set_host(0, a, 8'(a + 100));
         if (a % 3 == 1) set_host(1, a, 8'(a + 50));
         if (a % 5 == 0) begin set_host(0, a, 8'hA5); set_host(1, a, 8'hA5); end
      end
      do_pass(0, "R3 split", got);

      // R3 equal working values over unequal shadows
      for (int a = 0; a < 25; a++) begin
         set_host(0, a, 8'h3C);
         set_host(1, a, 8'h3C);
      end
      do_pass(0, "R3 rejoin", got);

      // R5 sweep: one register changed per pass on alternating sides
      for (int a = 0; a < 25; a++) begin
         set_host(a % 2, a, 8'(8'h3C + a + 1));
         do_pass(0, "R5 sweep", got);
         chk(got == 1, "R5 single write", got, 1);
      end

      // R10 write after the snapshot
      do_pass(1, "R10 during", got);
      do_pass(0, "R10 next", got);
      chk(got == 1, "R10 deferred write", got, 1);

      // R9 hold suppresses passes
      p0 = pass_cnt; c0 = lcount;
      repeat (300) @(negedge clk);
      chk(pass_cnt == p0, "R9 no pass while held", pass_cnt, p0);
      chk(lcount == c0, "R9 no write while held", lcount, c0);

      // R8 refresh while held, control register 11 with test bit set on the left
      set_host(0, 11, 8'h49);
      set_host(1, 7, 8'h11);
      p0 = pass_cnt;
      for (int a = 0; a < 25; a++) begin
         eL[a] = hL[a] + 8'd1; eR[a] = hR[a] + 8'd1;
         wL[a] = is_ctl(a) ? (hL[a] | 8'h08) : hL[a];
         wR[a] = is_ctl(a) ? (hR[a] | 8'h08) : hR[a];
      end
      @(negedge clk);
      refresh_req = 1'b1;
      @(negedge clk);
      refresh_req = 1'b0;
      wait_passes(p0 + 2);
      chk(pass_cnt == p0 + 2, "R11 two refresh passes", pass_cnt, p0 + 2);
      model_scan();
      check_pass(p0, "R8 test set", got);
      chk(got >= 25, "R8 all rewritten", got, 25);
      for (int a = 0; a < 25; a++) if (is_ctl(a)) begin
         wL[a] = wL[a] & 8'hF7; wR[a] = wR[a] & 8'hF7;
      end
      model_scan();
      check_pass(p0 + 1, "R8 test clear", got);
      do_pass(0, "R8 after", got);

      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      report();
   end

endmodule